// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded DAC Register Front End

This block is the digital side of a two-channel 12-bit converter that hangs off an 8-bit processor bus. The host loads each channel's code through two byte writes, a low byte and a high nibble, into a holding register. The two bytes may arrive in either order. The holding registers do not reach the converter codes until a separate active-low update strobe arrives. That strobe may come from an external timer and is asynchronous to the bus. One update moves both channels to their outputs on the same clock edge.

The bus is sampled in the block's clock domain. A write is committed on the clock edge at which the combined select-and-write strobe is first seen inactive, using the address and data held during the strobe's last active cycle. The update strobe passes through a two-flop synchronizer, and only its falling edge acts.

Top module: `dac_byte_front`

## Requirements
- R1: A synchronous active-high reset clears every holding register and both output codes to zero, so an update pulse right after reset leaves both codes at 0x000.
- R2: A write with bus_addr[0]=0 loads bus_data[7:0] into bits 7:0 of a holding register. bus_addr[1]=0 selects channel A and bus_addr[1]=1 selects channel B.
- R3: A write with bus_addr[0]=1 loads bus_data[3:0] into bits 11:8 of the selected channel's holding register. bus_data[7:4] are ignored on such a write.
- R4: The final code of a channel does not depend on whether its low byte or its high nibble is written first.
- R5: Writes never change code_a or code_b. The outputs change only on an update transfer.
- R6: One update transfer copies both holding registers to code_a and code_b on the same clock edge.
- R7: Each high-to-low transition of upd_n causes exactly one transfer. Holding upd_n low, and its return high, cause no further transfer.
- R8: A write takes effect only while bus_sel_n and bus_wr_n are both low. It commits on the edge where that combined strobe is first sampled inactive. With bus_sel_n high, a bus_wr_n pulse has no effect.
- R9: When a write commit and an update transfer fall on the same edge, the transfer carries the holding contents from before that write, and the write stays held for the next update.
- R10: If upd_n is first sampled low at clock edge n, having been high at edge n-1, the codes change at edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_n | input | 1 | Active-low chip select from host decode |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_addr | input | 2 | Register select: bit 1 channel, bit 0 high/low half |
| bus_data | input | 8 | Right-justified write data |
| upd_n | input | 1 | Asynchronous active-low update strobe |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |

## Verification
A byte write commit and an update transfer can land on the same clock edge. The bench provokes this by lowering upd_n together with an active write strobe and releasing the strobe after two cycles, so that the commit coincides with the synchronized falling edge. The bench then expects the transfer to carry the old holding value and a later update to carry the new byte. A behavioural reference model, compared on every cycle, also meets this collision many times during a long stretch of random writes and update pulses.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;

  localparam int DATA_W_DEF = 8;
  localparam int CODE_W_DEF = 12;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

endpackage

// File: rtl/bus_capture.sv
module bus_capture #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);

  logic strobe_now;
  logic strobe_q;

  assign strobe_now = ~sel_n & ~wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      c_addr   <= '0;
      c_data   <= '0;
    end else begin
      strobe_q <= strobe_now;
      if (strobe_now) begin
        c_addr <= addr;
        c_data <= data;
      end
    end
  end

  // Commit at the end of the strobe, using the last values captured while it was active.
  assign commit = strobe_q & ~strobe_now;

endmodule

// File: rtl/update_sync.sv
module update_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_n,
  output logic fire
);

  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '1;
    end else begin
      sh <= {sh[SH_W-2:0], upd_n};
    end
  end

  // A falling edge seen at the synchronized end of the chain.
  assign fire = sh[SH_W-1] & ~sh[SH_W-2];

endmodule

// File: rtl/chan_latch.sv
module chan_latch #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] din,
  input  logic              xfer,
  output logic [CODE_W-1:0] hold,
  output logic [CODE_W-1:0] code
);

  localparam int HI_W = CODE_W - DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= din;
      if (wr_hi) hi_q <= din[HI_W-1:0];
    end
  end

  assign hold = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
    end else if (xfer) begin
      code <= hold;
    end
  end

endmodule

// File: rtl/dac_byte_front.sv
module dac_byte_front
  import dac_front_pkg::*;
#(
  parameter int DATA_W      = DATA_W_DEF,
  parameter int CODE_W      = CODE_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel_n,
  input  logic              bus_wr_n,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              upd_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);

  localparam int NUM_CH = 2;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int ADDR_W = CH_W + 1;

  logic              commit;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;
  logic              xfer;
  logic [CODE_W-1:0] hold [NUM_CH];
  logic [CODE_W-1:0] code [NUM_CH];
  logic [CODE_W-1:0] hold_a;
  logic [CODE_W-1:0] hold_b;

  bus_capture #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_cap (
    .clk   (clk),
    .rst   (rst),
    .sel_n (bus_sel_n),
    .wr_n  (bus_wr_n),
    .addr  (bus_addr),
    .data  (bus_data),
    .commit(commit),
    .c_addr(c_addr),
    .c_data(c_data)
  );

  update_sync #(
    .STAGES(SYNC_STAGES)
  ) u_upd (
    .clk  (clk),
    .rst  (rst),
    .upd_n(upd_n),
    .fire (xfer)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    logic wr_lo;
    logic wr_hi;

    assign hit   = commit && (c_addr[ADDR_W-1:1] == CH_W'(ch));
    assign wr_lo = hit && (half_e'(c_addr[0]) == HALF_LO);
    assign wr_hi = hit && (half_e'(c_addr[0]) == HALF_HI);

    chan_latch #(
      .DATA_W(DATA_W),
      .CODE_W(CODE_W)
    ) u_lat (
      .clk  (clk),
      .rst  (rst),
      .wr_lo(wr_lo),
      .wr_hi(wr_hi),
      .din  (c_data),
      .xfer (xfer),
      .hold (hold[ch]),
      .code (code[ch])
    );
  end

  assign code_a = code[0];
  assign code_b = code[1];
  assign hold_a = hold[0];
  assign hold_b = hold[1];

endmodule

// File: rtl/dac_front_chk.sv
module dac_front_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel_n,
  input logic              bus_wr_n,
  input logic              xfer,
  input logic              commit,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic [CODE_W-1:0] hold_a,
  input logic [CODE_W-1:0] hold_b
);

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (code_a == '0 && code_b == '0));

  p_hold_steady_r5: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> ($stable(code_a) && $stable(code_b)));

  // R6 and R9: both outputs take the pre-edge holding contents together
  p_both_move_r6: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (code_a == $past(hold_a) && code_b == $past(hold_b)));

  p_single_fire_r7: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer);

  p_commit_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    commit |-> ($past(!bus_sel_n && !bus_wr_n) && !(!bus_sel_n && !bus_wr_n)));

endmodule

bind dac_byte_front dac_front_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel_n(bus_sel_n),
  .bus_wr_n (bus_wr_n),
  .xfer     (xfer),
  .commit   (commit),
  .code_a   (code_a),
  .code_b   (code_b),
  .hold_a   (hold_a),
  .hold_b   (hold_b)
);

// File: tb/sim_dac_byte_front.sv
`timescale 1ns/1ps
module sim_dac_byte_front;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel_n = 1'b1;
  logic        bus_wr_n = 1'b1;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_data = 8'd0;
  logic        upd_n = 1'b1;
  logic [11:0] code_a;
  logic [11:0] code_b;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dac_byte_front u0 (
    .clk      (clk),
    .rst      (rst),
    .bus_sel_n(bus_sel_n),
    .bus_wr_n (bus_wr_n),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .upd_n    (upd_n),
    .code_a   (code_a),
    .code_b   (code_b)
  );

  // Behavioural reference model
  int m_lo [2];
  int m_hi [2];
  int m_out [2];
  bit m_prev_act;
  int m_addr;
  int m_data;
  bit m_uq [$];

  always @(posedge clk) begin
    bit act;
    bit fire;
    act = !bus_sel_n && !bus_wr_n;
    if (rst) begin
      foreach (m_lo[i]) begin
        m_lo[i] = 0;
        m_hi[i] = 0;
        m_out[i] = 0;
      end
      m_prev_act = 0;
      m_uq = '{1'b1, 1'b1, 1'b1};
    end else begin
      fire = (m_uq[1] == 1'b0) && (m_uq[2] == 1'b1);
      if (fire) begin
        foreach (m_out[i]) m_out[i] = m_hi[i] * 256 + m_lo[i];
      end
      if (m_prev_act && !act) begin
        if (m_addr % 2 == 1) m_hi[m_addr / 2] = m_data % 16;
        else m_lo[m_addr / 2] = m_data;
      end
      m_uq.push_front(upd_n);
      void'(m_uq.pop_back());
      m_prev_act = act;
      if (act) begin
        m_addr = int'(bus_addr);
        m_data = int'(bus_data);
      end
    end
  end

  task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %03h expected %03h", tag, got, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R5 R6 model code_a", code_a, 12'(m_out[0]));
      check("R5 R6 model code_b", code_b, 12'(m_out[1]));
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel_n = 1'b0; bus_wr_n = 1'b0; bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_sel_n = 1'b1; bus_wr_n = 1'b1;
    @(negedge clk);
  endtask

  // Pulses upd_n and checks both outputs move at the same, expected negedge
  task automatic pulse_update(string tag);
    logic [11:0] a0, b0;
    int ia, ib;
    @(negedge clk);
    a0 = code_a; b0 = code_b; ia = -1; ib = -1;
    upd_n = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i == 2) upd_n = 1'b1;
      if (ia < 0 && code_a !== a0) ia = i;
      if (ib < 0 && code_b !== b0) ib = i;
    end
    if (ia >= 0 && ib >= 0) begin
      vectors++;
      if (ia != ib) begin
        miscompares++;
        $display("FAIL R6 %s change cycle a=%0d b=%0d expected equal", tag, ia, ib);
      end
    end
    if (ia >= 0) begin
      vectors++;
      if (ia != 3) begin
        miscompares++;
        $display("FAIL R10 %s latency got %0d expected 3", tag, ia);
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: run hung, got cycle %0d expected finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset code_a", code_a, 12'h000);
    check("R1 reset code_b", code_b, 12'h000);
    rst = 1'b0;

    // R2 R3 R5: load both channels, outputs stay put
    bus_write(2'd0, 8'h5A);
    bus_write(2'd1, 8'hF3);
    bus_write(2'd3, 8'h0C);
    bus_write(2'd2, 8'h81);
    repeat (3) @(negedge clk);
    check("R5 no change on write a", code_a, 12'h000);
    check("R5 no change on write b", code_b, 12'h000);
    pulse_update("first");
    check("R2 R3 code_a", code_a, 12'h35A);
    check("R4 high-first code_b", code_b, 12'hC81);

    // R4: opposite orders on each channel
    bus_write(2'd1, 8'h07);
    bus_write(2'd0, 8'hE1);
    bus_write(2'd2, 8'hB4);
    bus_write(2'd3, 8'hA2);
    pulse_update("second");
    check("R4 high-first code_a", code_a, 12'h7E1);
    check("R3 R4 low-first code_b", code_b, 12'h2B4);

    // R8: write strobe with chip select high is ignored
    @(negedge clk);
    bus_sel_n = 1'b1; bus_wr_n = 1'b0; bus_addr = 2'd0; bus_data = 8'hFF;
    @(negedge clk);
    bus_wr_n = 1'b1;
    pulse_update("deselected");
    check("R8 deselected write code_a", code_a, 12'h7E1);

    // R7: held low gives one transfer only
    @(negedge clk);
    upd_n = 1'b0;
    repeat (6) @(negedge clk);
    bus_write(2'd0, 8'h00);
    repeat (6) @(negedge clk);
    check("R7 held low code_a", code_a, 12'h7E1);
    upd_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 rising edge code_a", code_a, 12'h7E1);
    pulse_update("after hold");
    check("R7 next pulse code_a", code_a, 12'h700);

    // R9: write commit and transfer on the same edge
    @(negedge clk);
    bus_sel_n = 1'b0; bus_wr_n = 1'b0; bus_addr = 2'd0; bus_data = 8'h99;
    upd_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_sel_n = 1'b1; bus_wr_n = 1'b1;
    @(negedge clk);
    check("R9 collision uses old code_a", code_a, 12'h700);
    upd_n = 1'b1;
    repeat (4) @(negedge clk);
    pulse_update("after collision");
    check("R9 held write code_a", code_a, 12'h799);

    // R1: reset clears holding registers too
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 re-reset code_a", code_a, 12'h000);
    rst = 1'b0;
    pulse_update("post reset");
    check("R1 cleared hold code_a", code_a, 12'h000);
    check("R1 cleared hold code_b", code_b, 12'h000);

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      bus_addr = 2'($urandom);
      bus_data = 8'($urandom);
      if ($urandom % 3 == 0) begin
        bus_sel_n = 1'($urandom % 4 == 0);
        bus_wr_n  = 1'b0;
      end else begin
        bus_sel_n = 1'b1;
        bus_wr_n  = 1'b1;
      end
      if ($urandom % 5 == 0) upd_n = ~upd_n;
    end
    @(negedge clk);
    bus_sel_n = 1'b1; bus_wr_n = 1'b1; upd_n = 1'b1;
    repeat (6) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule